// File: doc/BRIEF.md
# Burst SPI Master with Word FIFOs

This block is an SPI master that software drives through a small 32-bit register bus with four word addresses: control, status, a transmit FIFO and a receive FIFO. Software pushes 32-bit words into the transmit FIFO, programs the burst length, the clock mode, the clock rate and the chip-select choice, then sets the exchange bit. The block sends one continuous burst of 1 to 4096 bits on SCLK/MOSI, collects MISO into the receive FIFO one 32-bit word at a time, and raises a sticky completion flag.

A burst whose length is not a multiple of 32 begins with a short word. That word carries only the leftover bits, in its low-order positions. Every later word is a full word sent MSB first. The receive side mirrors this split, so a loopback returns the words that were written, with the short word's unused upper bits cleared. Four select lines, each with a programmable active level, let one controller serve four devices. Between words the selected line either stays asserted or drops for one SCLK period.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the control and status registers read 0, SCLK is low, MOSI is low, all four select lines are high (inactive for active-low), and a receive-FIFO read returns 0.
- R2: Control bit 0 enables the block, bit 1 selects master operation and bit 2 requests an exchange. A control write starts a burst only when all three are set. Otherwise the exchange bit reads back 0 and SCLK does not toggle.
- R3: The 3-bit rate field at control bits 18:16 holds a code n, and one SCLK period lasts 4<<n input clocks.
- R4: Control bits 31:20 hold the burst length minus one. The burst uses ceil(L/32) FIFO words. With r = L mod 32 non-zero, the first word sends its low r bits, bit r-1 first. All other words are sent bit 31 first. Received words are assembled the same way, with the first word's bits above r reading 0.
- R5: Control bit 4 sets the idle SCLK level. With bit 5 clear, MOSI is valid before the first edge of each bit and is sampled on that edge. With bit 5 set, MOSI changes on the first edge and is sampled on the second. All four combinations transfer correctly.
- R6: Control bits 13:12 choose which of the four select lines is asserted during the burst, and bit 7 sets the asserted level (1 = high). The other three lines stay at the inactive level.
- R7: With control bit 6 set, the select line stays asserted for the whole burst. With it clear, the line drops for one SCLK period between consecutive 32-bit words.
- R8: Status bit 7 sets when the last bit of the burst is shifted, and the exchange bit then reads 0. Writing 1 to status bit 7 or bit 6 clears that bit.
- R9: While a burst runs, control writes are ignored. The exception is a write with bit 0 clear, which stops the burst at once, idles SCLK and the select lines, and empties both FIFOs.
- R10: Each FIFO holds 8 words. A received word that finds the receive FIFO full is dropped and sets status bit 6. Reading an empty receive FIFO returns 0, and an empty transmit FIFO supplies zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 3) |
| reg_addr | input | 2 | Word address: 0 control, 1 status, 2 transmit data, 3 receive data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle the address is presented |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 4 | Chip-select lines |

## Verification
A bit counter or word counter that is off by one shows at the ports when the burst ends. The captured MOSI stream has the wrong length, the short first word is misaligned in the receive FIFO, or the exchange bit clears one SCLK period early or late. A clock-phase or shift-register fault shows within the first word as a loopback word that differs from the one written. A sequencing fault around word boundaries shows within one SCLK period as a wrong number of select-line activations. A fault in the abort or flush path shows on the next burst, as stale data where zeros are expected.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 12;
    localparam int RATE_W  = 3;
    localparam int CSSEL_W = 2;
    localparam int NCS     = 1 << CSSEL_W;
    localparam int BITS_W  = $clog2(WORD_W) + 1;
    localparam int WCNT_W  = LEN_W - $clog2(WORD_W) + 1;
    localparam int CNT_W   = (1 << RATE_W) + 2;

    // control word; field positions are decoded by software
    typedef struct packed {
        logic [LEN_W-1:0]   len_m1;
        logic               rsv19;
        logic [RATE_W-1:0]  rate;
        logic [1:0]         rsv15;
        logic [CSSEL_W-1:0] cs_sel;
        logic [3:0]         rsv11;
        logic               ss_high;
        logic               cs_hold;
        logic               cpha;
        logic               cpol;
        logic               rsv3;
        logic               xch;
        logic               master;
        logic               en;
    } ctrl_t;

    localparam logic [WORD_W-1:0] CTRL_WMASK = 32'hFFF7_30F7;
    localparam int STAT_TC  = 7;
    localparam int STAT_OVF = 6;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_TXD  = 2'd2,
        A_RXD  = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        E_IDLE, E_LOAD, E_LEAD, E_TRAIL, E_GAP
    } eng_st_e;

    function automatic logic [CNT_W-1:0] half_cycles(input logic [RATE_W-1:0] rate);
        return CNT_W'(2) << rate;
    endfunction

    function automatic logic [WCNT_W-1:0] word_count(input logic [LEN_W-1:0] lm1);
        return WCNT_W'(({1'b0, lm1} + (LEN_W+1)'(WORD_W)) >> $clog2(WORD_W));
    endfunction

    function automatic logic [BITS_W-1:0] first_bits(input logic [LEN_W-1:0] lm1);
        logic [BITS_W-2:0] r;
        r = lm1[BITS_W-2:0] + 1'b1;
        return (r == '0) ? BITS_W'(WORD_W) : {1'b0, r};
    endfunction

endpackage

// File: rtl/spi_burst_fifo.sv
`timescale 1ns/1ps
module spi_burst_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             empty, do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R10
    fifo_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/spi_burst_engine.sv
`timescale 1ns/1ps
module spi_burst_engine
    import spi_burst_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                abort,
    input  logic                cpol,
    input  logic                cpha,
    input  logic                cs_hold,
    input  logic [RATE_W-1:0]   rate,
    input  logic [LEN_W-1:0]    len_m1,
    input  logic [WORD_W-1:0]   tx_word,
    output logic                tx_pop,
    input  logic                miso,
    output logic [WORD_W-1:0]   rx_word,
    output logic                rx_push,
    output logic                done,
    output logic                busy,
    output logic                sclk,
    output logic                mosi,
    output logic                cs_act
);
    eng_st_e             st;
    logic [CNT_W-1:0]    cnt, half;
    logic [WORD_W-1:0]   txs, rxs, rx_next, load_word;
    logic [BITS_W-1:0]   bits_left, nb;
    logic [WCNT_W-1:0]   words_left;
    logic                first, lvl, mosi_q, tick, last_bit;

    assign half      = half_cycles(rate);
    assign tick      = (cnt == '0);
    assign nb        = first ? first_bits(len_m1) : BITS_W'(WORD_W);
    assign load_word = tx_word << (BITS_W'(WORD_W) - nb);
    assign rx_next   = {rxs[WORD_W-2:0], miso};
    assign last_bit  = (st == E_TRAIL) && tick && (bits_left == BITS_W'(1));

    assign rx_word = cpha ? rx_next : rxs;
    assign rx_push = last_bit;
    assign done    = last_bit && (words_left == WCNT_W'(1));
    assign tx_pop  = (st == E_LOAD);
    assign busy    = (st != E_IDLE);
    assign cs_act  = (st == E_LOAD) || (st == E_LEAD) || (st == E_TRAIL);
    assign sclk    = cpol ^ lvl;
    assign mosi    = mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= E_IDLE;
            cnt        <= '0;
            txs        <= '0;
            rxs        <= '0;
            bits_left  <= '0;
            words_left <= '0;
            first      <= 1'b0;
            lvl        <= 1'b0;
            mosi_q     <= 1'b0;
        end else if (abort) begin
            st  <= E_IDLE;
            lvl <= 1'b0;
        end else begin
            case (st)
                E_IDLE: if (start) begin
                    st    <= E_LOAD;
                    first <= 1'b1;
                end
                E_LOAD: begin
                    if (first) words_left <= word_count(len_m1);
                    bits_left <= nb;
                    rxs       <= '0;
                    cnt       <= half - 1'b1;
                    st        <= E_LEAD;
                    if (!cpha) begin
                        mosi_q <= load_word[WORD_W-1];
                        txs    <= load_word << 1;
                    end else begin
                        txs    <= load_word;
                    end
                end
                E_LEAD: if (tick) begin
                    lvl <= 1'b1;
                    cnt <= half - 1'b1;
                    st  <= E_TRAIL;
                    if (cpha) begin
                        mosi_q <= txs[WORD_W-1];
                        txs    <= txs << 1;
                    end else begin
                        rxs    <= rx_next;
                    end
                end else cnt <= cnt - 1'b1;
                E_TRAIL: if (tick) begin
                    lvl       <= 1'b0;
                    bits_left <= bits_left - 1'b1;
                    if (cpha) rxs <= rx_next;
                    if (bits_left != BITS_W'(1)) begin
                        cnt <= half - 1'b1;
                        st  <= E_LEAD;
                        if (!cpha) begin
                            mosi_q <= txs[WORD_W-1];
                            txs    <= txs << 1;
                        end
                    end else begin
                        first      <= 1'b0;
                        words_left <= words_left - 1'b1;
                        if (words_left == WCNT_W'(1)) st <= E_IDLE;
                        else if (cs_hold)             st <= E_LOAD;
                        else begin
                            cnt <= (half << 1) - 1'b1;
                            st  <= E_GAP;
                        end
                    end
                end else cnt <= cnt - 1'b1;
                E_GAP: if (tick) st <= E_LOAD;
                       else      cnt <= cnt - 1'b1;
                default: st <= E_IDLE;
            endcase
        end
    end

    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == E_TRAIL && $past(st == E_TRAIL)) |-> $stable(mosi_q));

    // R7
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_hold && busy && $past(busy) && $past(cs_act)) |-> cs_act);

    // R3
    edge_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lvl) && !$past(abort)) |-> $past(tick));

endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_out
);
    ctrl_t             ctrl_q, ctrl_new;
    reg_addr_e         addr;
    logic              tc_q, ovf_q;
    logic              wr_ctrl, wr_stat, wr_tx, rd_rx;
    logic              start, abort, busy, done, cs_act;
    logic              tx_pop, tx_full, rx_push, rx_full;
    logic [WORD_W-1:0] tx_word, rx_word, rx_head;

    assign addr     = reg_addr_e'(reg_addr);
    assign wr_ctrl  = reg_wr && (addr == A_CTRL);
    assign wr_stat  = reg_wr && (addr == A_STAT);
    assign wr_tx    = reg_wr && (addr == A_TXD);
    assign rd_rx    = reg_rd && (addr == A_RXD);
    assign ctrl_new = ctrl_t'(reg_wdata & CTRL_WMASK);
    assign start    = wr_ctrl && !busy && ctrl_new.en && ctrl_new.master && ctrl_new.xch;
    assign abort    = wr_ctrl && busy && !ctrl_new.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tc_q   <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_ctrl && (!busy || abort)) begin
                ctrl_q     <= ctrl_new;
                ctrl_q.xch <= start;
            end else if (done) begin
                ctrl_q.xch <= 1'b0;
            end
            tc_q  <= done || (tc_q && !(wr_stat && reg_wdata[STAT_TC]));
            ovf_q <= (rx_push && rx_full) || (ovf_q && !(wr_stat && reg_wdata[STAT_OVF]));
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_STAT:  reg_rdata = WORD_W'({tc_q, ovf_q}) << STAT_OVF;
            A_RXD:   reg_rdata = rx_head;
            default: reg_rdata = '0;
        endcase
    end

    spi_burst_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(abort),
        .push(wr_tx), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_word), .full(tx_full)
    );

    spi_burst_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(abort),
        .push(rx_push), .din(rx_word),
        .pop(rd_rx), .dout(rx_head), .full(rx_full)
    );

    spi_burst_engine u_eng (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .cs_hold(ctrl_q.cs_hold),
        .rate(ctrl_q.rate), .len_m1(ctrl_q.len_m1),
        .tx_word(tx_word), .tx_pop(tx_pop), .miso(miso),
        .rx_word(rx_word), .rx_push(rx_push), .done(done), .busy(busy),
        .sclk(sclk), .mosi(mosi), .cs_act(cs_act)
    );

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_out[g] = (cs_act && ctrl_q.cs_sel == CSSEL_W'(g)) ? ctrl_q.ss_high
                                                                     : !ctrl_q.ss_high;
    end

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == ctrl_q.cpol));

    // R8
    tc_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_q) |-> $past(done));

    // R8
    xch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !abort) |=> !ctrl_q.xch);

    // R10
    ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $past(rx_push && rx_full));

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ctrl_q));

    // R10
    tx_full_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !tx_pop && !abort) |=> tx_full);

endmodule

// File: tb/tb_spi_burst_master.sv
`timescale 1ns/1ps
module tb_spi_burst_master;

    localparam logic [1:0] AD_CTRL = 2'd0, AD_STAT = 2'd1, AD_TXD = 2'd2, AD_RXD = 2'd3;

    typedef struct packed {
        logic [1:0]  mode;
        logic [11:0] lenm1;
        logic [31:0] w0;
        logic [31:0] w1;
        logic        hold;
        logic        pol;
        logic [1:0]  sel;
        logic [2:0]  rate;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 12'd7,  32'h0000_00A5, 32'h0000_0000, 1'b1, 1'b0, 2'd0, 3'd0},
        '{2'd1, 12'd23, 32'h00C3_5A7E, 32'h0000_0000, 1'b0, 1'b1, 2'd1, 3'd0},
        '{2'd2, 12'd31, 32'hDEAD_BEEF, 32'h0000_0000, 1'b1, 1'b0, 2'd2, 3'd1},
        '{2'd3, 12'd39, 32'h0000_005B, 32'h1234_5678, 1'b0, 1'b0, 2'd3, 3'd0},
        '{2'd0, 12'd63, 32'hF0E1_D2C3, 32'h0F1E_2D3C, 1'b0, 1'b1, 2'd0, 3'd0},
        '{2'd1, 12'd63, 32'hA5A5_0FF0, 32'h8001_7FFE, 1'b1, 1'b0, 2'd1, 3'd1},
        '{2'd2, 12'd39, 32'hFFFF_FFC3, 32'hCAFE_F00D, 1'b1, 1'b1, 2'd2, 3'd0},
        '{2'd3, 12'd7,  32'h0000_003C, 32'h0000_0000, 1'b0, 1'b1, 2'd3, 3'd2},
        '{2'd0, 12'd23, 32'h0081_2244, 32'h0000_0000, 1'b1, 1'b0, 2'd1, 3'd0},
        '{2'd2, 12'd63, 32'h1357_9BDF, 32'h2468_ACE0, 1'b0, 1'b0, 2'd0, 3'd0},
        '{2'd3, 12'd31, 32'h8000_0001, 32'h0000_0000, 1'b1, 1'b1, 2'd2, 3'd0},
        '{2'd1, 12'd39, 32'h0000_00FE, 32'h0000_0001, 1'b0, 1'b0, 2'd0, 3'd0}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_out;

    assign miso = mosi;  // loopback slave

    spi_burst_master dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_out(cs_out)
    );

    always #5 clk = ~clk;

    int nvec = 0, nmis = 0, cyc = 0;

    // serial monitor state
    logic        mon_cpol = 0, mon_cpha = 0, mon_pol = 0, prev_sclk = 0, prev_act = 0;
    logic [1:0]  mon_sel = 0;
    logic        cap [0:511];
    int          ncap = 0, lead_cnt = 0, first_lead = 0, period = 0, act_cnt = 0, bad_cs = 0;
    logic        lead_e, act_e;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            nmis++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (sclk !== prev_sclk) begin
            lead_e = (prev_sclk == mon_cpol);
            if (lead_e == !mon_cpha && ncap < 512) begin
                cap[ncap] = mosi;
                ncap++;
            end
            if (lead_e) begin
                lead_cnt++;
                if (lead_cnt == 1) first_lead = cyc;
                if (lead_cnt == 2) period = cyc - first_lead;
            end
        end
        prev_sclk = sclk;
        for (int i = 0; i < 4; i++) begin
            act_e = (cs_out[i] == mon_pol);
            if (i == int'(mon_sel)) begin
                if (act_e && !prev_act) act_cnt++;
                prev_act = act_e;
            end else if (act_e) bad_cs++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int k = 0; k < 5000; k++) begin
            bus_rd(AD_CTRL, d);
            if (!d[2]) break;
        end
    endtask

    task automatic mon_clear(input logic cp, input logic ph, input logic pl, input logic [1:0] s);
        mon_cpol = cp; mon_cpha = ph; mon_pol = pl; mon_sel = s;
        prev_sclk = sclk; prev_act = 1'b0;
        ncap = 0; lead_cnt = 0; period = 0; act_cnt = 0; bad_cs = 0;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic en, input logic ms, input logic xch,
            input logic [1:0] mode, input logic hold, input logic pol,
            input logic [1:0] sel, input logic [2:0] rate, input logic [11:0] lm1);
        return {lm1, 1'b0, rate, 2'b00, sel, 4'b0000, pol, hold, mode[0], mode[1],
                1'b0, xch, ms, en};
    endfunction

    task automatic run_vec(input vec_t t);
        logic [31:0] c, d, m0;
        int L, r, nw, errs;
        logic eb;
        L  = int'(t.lenm1) + 1;
        r  = L % 32;
        nw = (L + 31) / 32;
        c  = mk_ctrl(1, 1, 0, t.mode, t.hold, t.pol, t.sel, t.rate, t.lenm1);
        bus_wr(AD_CTRL, c);
        bus_wr(AD_TXD, t.w0);
        if (nw > 1) bus_wr(AD_TXD, t.w1);
        mon_clear(t.mode[1], t.mode[0], t.pol, t.sel);
        bus_wr(AD_CTRL, c | 32'h4);
        wait_idle();
        bus_rd(AD_STAT, d);  check("R8 done flag set", d, 32'h80);
        bus_wr(AD_STAT, 32'hC0);
        bus_rd(AD_STAT, d);  check("R8 done flag cleared", d, 32'h0);
        m0 = (r != 0) ? (t.w0 & ((32'h1 << r) - 1)) : t.w0;
        bus_rd(AD_RXD, d);   check("R4 first rx word", d, m0);
        if (nw > 1) begin
            bus_rd(AD_RXD, d); check("R4 second rx word", d, t.w1);
        end
        errs = 0;
        for (int i = 0; i < L; i++) begin
            if (r != 0) eb = (i < r) ? t.w0[r-1-i] : t.w1[31-(i-r)];
            else        eb = (i < 32) ? t.w0[31-i] : t.w1[31-(i-32)];
            if (cap[i] !== eb) errs++;
        end
        check("R4 mosi bit count", ncap, L);
        check("R5 mosi stream order in mode", errs, 0);
        check("R3 sclk period", period, 32'd4 << t.rate);
        check("R7 select activations", act_cnt, t.hold ? 1 : nw);
        check("R6 unselected lines quiet", bad_cs, 0);
        check("R6 idle select level", cs_out, t.pol ? 4'h0 : 4'hF);
    endtask

    initial begin : main
        logic [31:0] d, c;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check("R1 sclk after reset", sclk, 0);
        check("R1 mosi after reset", mosi, 0);
        check("R1 selects after reset", cs_out, 4'hF);
        bus_rd(AD_CTRL, d); check("R1 control after reset", d, 0);
        bus_rd(AD_STAT, d); check("R1 status after reset", d, 0);
        bus_rd(AD_RXD, d);  check("R1 empty rx after reset", d, 0);

        // vector table: loopback bursts in all four modes
        for (int v = 0; v < NV; v++) run_vec(VECS[v]);

        // R2: exchange without master bit does not start
        mon_clear(0, 0, 0, 0);
        c = mk_ctrl(1, 0, 1, 2'd0, 0, 0, 0, 0, 12'd7);
        bus_wr(AD_CTRL, c);
        repeat (40) @(negedge clk);
        check("R2 no sclk without master", lead_cnt, 0);
        bus_rd(AD_CTRL, d); check("R2 exchange bit not kept", d, c & ~32'h4);
        c = mk_ctrl(0, 1, 1, 2'd0, 0, 0, 0, 0, 12'd7);
        bus_wr(AD_CTRL, c);
        repeat (40) @(negedge clk);
        check("R2 no sclk without enable", lead_cnt, 0);
        bus_rd(AD_STAT, d); check("R2 no completion", d, 0);

        // R9: ignored write, then abort and flush
        c = mk_ctrl(1, 1, 0, 2'd0, 1, 0, 2'd1, 3'd3, 12'd63);
        bus_wr(AD_CTRL, c);
        bus_wr(AD_TXD, 32'h1111_2222);
        bus_wr(AD_TXD, 32'h3333_4444);
        bus_wr(AD_CTRL, c | 32'h4);
        repeat (20) @(negedge clk);
        bus_wr(AD_CTRL, mk_ctrl(1, 1, 0, 2'd1, 0, 1, 2'd3, 3'd0, 12'd7));
        bus_rd(AD_CTRL, d); check("R9 write ignored while busy", d, c | 32'h4);
        bus_wr(AD_CTRL, 32'h0);
        bus_rd(AD_CTRL, d); check("R9 abort clears control", d, 0);
        check("R9 selects idle after abort", cs_out, 4'hF);
        check("R9 sclk idle after abort", sclk, 0);
        bus_rd(AD_STAT, d); check("R9 no completion on abort", d, 0);
        bus_rd(AD_RXD, d);  check("R9 rx flushed", d, 0);
        c = mk_ctrl(1, 1, 0, 2'd0, 1, 0, 2'd0, 3'd0, 12'd31);
        bus_wr(AD_CTRL, c);
        bus_wr(AD_CTRL, c | 32'h4);
        wait_idle();
        bus_rd(AD_RXD, d);  check("R9 tx flushed so zeros sent (R10)", d, 0);
        bus_rd(AD_STAT, d); check("R8 completion after flushed burst", d, 32'h80);
        bus_wr(AD_STAT, 32'h80);

        // R10: ten-word burst with eight-word receive FIFO
        c = mk_ctrl(1, 1, 0, 2'd0, 1, 0, 2'd0, 3'd0, 12'd319);
        bus_wr(AD_CTRL, c);
        for (int k = 0; k < 8; k++) bus_wr(AD_TXD, 32'h0101_0101 * (k + 1));
        bus_wr(AD_CTRL, c | 32'h4);
        wait_idle();
        bus_rd(AD_STAT, d); check("R10 overflow and done flags", d, 32'hC0);
        for (int k = 0; k < 8; k++) begin
            bus_rd(AD_RXD, d); check("R10 kept rx word", d, 32'h0101_0101 * (k + 1));
        end
        bus_rd(AD_RXD, d);  check("R10 empty rx reads zero", d, 0);
        bus_wr(AD_STAT, 32'h40);
        bus_rd(AD_STAT, d); check("R8 clear overflow only", d, 32'h80);
        bus_wr(AD_STAT, 32'h80);
        bus_rd(AD_STAT, d); check("R8 clear done", d, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

endmodule